// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block is a FIFO for 9-bit words with a separate write clock and read clock. It runs in first-word-fall-through fashion. The oldest stored word is moved into an output register without a read request. An active-low valid flag marks that the output register holds data. Asserting the read enable consumes the word on display, and the next stored word takes its place on the following read-clock edge.

Status flags are computed in two places. The full, half-full and almost-full flags come from the write side. The almost-empty flag comes from the read side. Every threshold flag uses the count of words held in the memory array. The word already sitting in the output register is not part of that count, so the total capacity is DEPTH + 1 words.

The two threshold offsets are captured while the synchronous master reset is high. They are taken either from two parallel inputs or, when the default-select input is high, from a parameter value. The write and read pointers cross between the clock domains as Gray code through two register stages.

Top module: `fwft_fifo`

## Requirements
- R1: While `rst` is high and after it falls, with no write yet, the outputs are: `rd_valid_n`=1, `wr_space_n`=0, `half_full_n`=1, `almost_full_n`=1, `almost_empty_n`=0.
- R2: A word written into an empty FIFO appears on `dout` with `rd_valid_n` low, without any read. This happens on the third or fourth rising `rclk` edge after the `wclk` edge that stored it.
- R3: `wr_space_n` is 1 exactly when the memory count equals DEPTH. A write attempted while it is 1 changes no pointer, no flag and no stored data.
- R4: A read while `rd_valid_n` is 1 is ignored. `rd_valid_n` rises only on an `rclk` edge where `rd_en` was 1, which happens when that read consumes the output word while the memory is empty.
- R5: Words leave through `dout` in the order they were accepted, with no loss and no duplication, including during simultaneous writing and reading.
- R6: While `rd_valid_n` is 0 and `rd_en` is 0, `dout` and `rd_valid_n` hold their values.
- R7: The word held in the output register is excluded from the memory count used by every threshold flag. A single stored word therefore gives a count of 0.
- R8: `almost_empty_n` is 0 exactly when the memory count is at most the empty offset n.
- R9: `almost_full_n` is 0 exactly when the memory count is at least DEPTH − m, where m is the full offset.
- R10: `half_full_n` is 0 exactly when the memory count exceeds DEPTH/2.
- R11: n is taken from `empty_ofs` and m from `full_ofs` while `rst` is high. If `ofs_default` is 1 during reset, both offsets are the parameter DEF_OFS instead (127 by default).
- R12: Each pointer crosses domains as a Gray code that changes in at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high master reset, seen by both domains |
| ofs_default | input | 1 | During reset: 1 selects DEF_OFS for both offsets |
| empty_ofs | input | $clog2(DEPTH)+1 | Empty offset n, captured during reset |
| full_ofs | input | $clog2(DEPTH)+1 | Full offset m, captured during reset |
| wr_en | input | 1 | Write request |
| din | input | 9 | Write data |
| rd_en | input | 1 | Read request (consume the displayed word) |
| dout | output | 9 | Output register |
| rd_valid_n | output | 1 | Low when `dout` holds a valid word |
| wr_space_n | output | 1 | High when the memory is full |
| half_full_n | output | 1 | Low when the memory count exceeds DEPTH/2 |
| almost_full_n | output | 1 | Low when the memory count is at least DEPTH − m |
| almost_empty_n | output | 1 | Low when the memory count is at most n |

## Verification
Several properties are checked on every cycle:
- a write into a full memory leaves the write pointer unchanged;
- the valid flag only rises after a read request;
- the output register stays frozen while no read is requested;
- full always implies almost-full and half-full;
- both Gray pointers move by at most one bit per clock.

Other behaviour is shown only by the bench scenarios. These include the exact flag thresholds for several offset settings, including the default, and the exclusion of the output-register word from the count. They also include the first-word latency window and the data order under concurrent traffic. All of these are judged after the synchronizers have settled, against a count the bench computes itself.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

    localparam int WORD_W = 9;

    typedef logic [WORD_W-1:0] word_t;

    // write-domain status bundle
    typedef struct packed {
        logic space_n;
        logic half_n;
        logic afull_n;
    } wr_flags_t;

    function automatic logic [31:0] to_gray(logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fwft_ptr_sync.sv
module fwft_ptr_sync #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] stage1, stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    assign bin_out = PW'(fwft_pkg::from_gray(32'(stage2)));
endmodule

// File: rtl/fwft_wr_ctrl.sv
module fwft_wr_ctrl
    import fwft_pkg::*;
#(
    parameter  int DEPTH   = 256,
    parameter  int DEF_OFS = 127,
    localparam int AW      = $clog2(DEPTH),
    localparam int PW      = AW + 1
) (
    input  logic          wclk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          ofs_default,
    input  logic [PW-1:0] full_ofs,
    input  logic [PW-1:0] rptr_bin,
    output logic [PW-1:0] wptr_bin,
    output logic [PW-1:0] wptr_gray,
    output logic          wr_fire,
    output wr_flags_t     flags
);
    localparam logic [PW-1:0] DEPTH_C = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_C  = PW'(DEPTH / 2);

    logic [PW-1:0] m_q, used, wptr_nxt;

    // conservative count: the read pointer seen here lags the real one
    assign used     = wptr_bin - rptr_bin;
    assign wptr_nxt = wptr_bin + PW'(1);

    always_comb begin
        flags.space_n = (used == DEPTH_C);
        flags.half_n  = !(used > HALF_C);
        flags.afull_n = !(used >= (DEPTH_C - m_q));
    end

    assign wr_fire = wr_en && !flags.space_n;

    always_ff @(posedge wclk) begin
        if (rst) begin
            wptr_bin  <= '0;
            wptr_gray <= '0;
            m_q       <= ofs_default ? PW'(DEF_OFS) : full_ofs;
        end else if (wr_fire) begin
            wptr_bin  <= wptr_nxt;
            wptr_gray <= PW'(to_gray(32'(wptr_nxt)));
        end
    end
endmodule

// File: rtl/fwft_rd_ctrl.sv
module fwft_rd_ctrl
    import fwft_pkg::*;
#(
    parameter  int DEPTH   = 256,
    parameter  int DEF_OFS = 127,
    localparam int AW      = $clog2(DEPTH),
    localparam int PW      = AW + 1
) (
    input  logic          rclk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          ofs_default,
    input  logic [PW-1:0] empty_ofs,
    input  logic [PW-1:0] wptr_bin,
    input  word_t         mem_q,
    output logic [PW-1:0] rptr_bin,
    output logic [PW-1:0] rptr_gray,
    output word_t         dout,
    output logic          rd_valid_n,
    output logic          almost_empty_n
);
    logic [PW-1:0] n_q, held, rptr_nxt;
    logic          have, load;

    // words still in the array; the displayed word is already excluded
    assign held     = wptr_bin - rptr_bin;
    assign have     = (held != '0);
    assign load     = have && (rd_valid_n || rd_en);
    assign rptr_nxt = rptr_bin + PW'(1);

    assign almost_empty_n = !(held <= n_q);

    always_ff @(posedge rclk) begin
        if (rst) begin
            rptr_bin   <= '0;
            rptr_gray  <= '0;
            dout       <= '0;
            rd_valid_n <= 1'b1;
            n_q        <= ofs_default ? PW'(DEF_OFS) : empty_ofs;
        end else if (load) begin
            rptr_bin   <= rptr_nxt;
            rptr_gray  <= PW'(to_gray(32'(rptr_nxt)));
            dout       <= mem_q;
            rd_valid_n <= 1'b0;
        end else if (rd_en) begin
            rd_valid_n <= 1'b1;
        end
    end
endmodule

// File: rtl/fwft_fifo.sv
module fwft_fifo
    import fwft_pkg::*;
#(
    parameter  int DEPTH   = 256,
    parameter  int DEF_OFS = 127,
    localparam int AW      = $clog2(DEPTH),
    localparam int PW      = AW + 1
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              ofs_default,
    input  logic [PW-1:0]     empty_ofs,
    input  logic [PW-1:0]     full_ofs,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] din,
    input  logic              rd_en,
    output logic [WORD_W-1:0] dout,
    output logic              rd_valid_n,
    output logic              wr_space_n,
    output logic              half_full_n,
    output logic              almost_full_n,
    output logic              almost_empty_n
);
    logic [PW-1:0] w_bin, w_gray, r_bin, r_gray;
    logic [PW-1:0] w_bin_rd, r_bin_wr;
    logic          w_fire;
    wr_flags_t     wflags;
    word_t         mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (w_fire) begin
            mem[w_bin[AW-1:0]] <= din;
        end
    end

    fwft_wr_ctrl #(.DEPTH(DEPTH), .DEF_OFS(DEF_OFS)) u_wr (
        .wclk        (wclk),
        .rst         (rst),
        .wr_en       (wr_en),
        .ofs_default (ofs_default),
        .full_ofs    (full_ofs),
        .rptr_bin    (r_bin_wr),
        .wptr_bin    (w_bin),
        .wptr_gray   (w_gray),
        .wr_fire     (w_fire),
        .flags       (wflags)
    );

    fwft_ptr_sync #(.PW(PW)) u_r2w (
        .clk     (wclk),
        .rst     (rst),
        .gray_in (r_gray),
        .bin_out (r_bin_wr)
    );

    fwft_ptr_sync #(.PW(PW)) u_w2r (
        .clk     (rclk),
        .rst     (rst),
        .gray_in (w_gray),
        .bin_out (w_bin_rd)
    );

    fwft_rd_ctrl #(.DEPTH(DEPTH), .DEF_OFS(DEF_OFS)) u_rd (
        .rclk           (rclk),
        .rst            (rst),
        .rd_en          (rd_en),
        .ofs_default    (ofs_default),
        .empty_ofs      (empty_ofs),
        .wptr_bin       (w_bin_rd),
        .mem_q          (mem[r_bin[AW-1:0]]),
        .rptr_bin       (r_bin),
        .rptr_gray      (r_gray),
        .dout           (dout),
        .rd_valid_n     (rd_valid_n),
        .almost_empty_n (almost_empty_n)
    );

    assign wr_space_n    = wflags.space_n;
    assign half_full_n   = wflags.half_n;
    assign almost_full_n = wflags.afull_n;
endmodule

// File: rtl/fwft_fifo_chk.sv
module fwft_fifo_chk #(
    parameter int PW = 9
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          wr_space_n,
    input logic          rd_valid_n,
    input logic          almost_full_n,
    input logic          half_full_n,
    input logic [8:0]    dout,
    input logic [PW-1:0] w_bin,
    input logic [PW-1:0] w_gray,
    input logic [PW-1:0] r_gray
);
    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (rst)
        (wr_space_n && wr_en) |=> $stable(w_bin));

    p_valid_rises_on_read_r4: assert property (@(posedge rclk) disable iff (rst)
        $rose(rd_valid_n) |-> $past(rd_en));

    p_output_held_r6: assert property (@(posedge rclk) disable iff (rst)
        (!rd_valid_n && !rd_en) |=> (!rd_valid_n && $stable(dout)));

    // R9 and R10: full lies above both thresholds
    p_full_above_thresholds_r9: assert property (@(posedge wclk) disable iff (rst)
        wr_space_n |-> (!almost_full_n && !half_full_n));

    p_wgray_step_r12: assert property (@(posedge wclk) disable iff (rst)
        $onehot0(w_gray ^ $past(w_gray)));

    p_rgray_step_r12: assert property (@(posedge rclk) disable iff (rst)
        $onehot0(r_gray ^ $past(r_gray)));
endmodule

bind fwft_fifo fwft_fifo_chk #(.PW(PW)) u_chk (
    .wclk          (wclk),
    .rclk          (rclk),
    .rst           (rst),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .wr_space_n    (wr_space_n),
    .rd_valid_n    (rd_valid_n),
    .almost_full_n (almost_full_n),
    .half_full_n   (half_full_n),
    .dout          (dout),
    .w_bin         (w_bin),
    .w_gray        (w_gray),
    .r_gray        (r_gray)
);

// File: tb/fwft_fifo_bench.sv
`timescale 1ns/100ps
module fwft_fifo_bench;
    localparam int DEPTH = 16;
    localparam int PW    = 5;
    localparam int DEFO  = 2;
    localparam int NSTR  = 40;

    logic          wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
    logic          ofs_default = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [PW-1:0] empty_ofs = '0, full_ofs = '0;
    logic [8:0]    din = '0;
    logic [8:0]    dout;
    logic          rd_valid_n, wr_space_n, half_full_n, almost_full_n, almost_empty_n;

    int vecs = 0, errs = 0;
    int n_cur = 0, m_cur = 0;
    logic [8:0] model[$];

    fwft_fifo #(.DEPTH(DEPTH), .DEF_OFS(DEFO)) u_fwft_fifo (
        .wclk(wclk), .rclk(rclk), .rst(rst), .ofs_default(ofs_default),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .wr_en(wr_en), .din(din),
        .rd_en(rd_en), .dout(dout), .rd_valid_n(rd_valid_n), .wr_space_n(wr_space_n),
        .half_full_n(half_full_n), .almost_full_n(almost_full_n),
        .almost_empty_n(almost_empty_n)
    );

    always #2.5 wclk = ~wclk;
    initial begin
        #1;
        forever #3.5 rclk = ~rclk;
    end

    function automatic logic [8:0] val(int i);
        return 9'((i * 37 + 5) & 9'h1FF);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge rclk);
        repeat (6) @(posedge wclk);
        @(negedge wclk);
    endtask

    task automatic check_flags();
        int stored, cnt;
        stored = model.size();
        cnt    = (stored > 0) ? stored - 1 : 0;
        chk("R4 output-ready", 32'(rd_valid_n), 32'(stored == 0));
        if (stored > 0) chk("R5 R6 head data", 32'(dout), 32'(model[0]));
        chk("R3 full", 32'(wr_space_n), 32'(cnt == DEPTH));
        chk("R7 R10 half-full", 32'(half_full_n), 32'(!(cnt > DEPTH / 2)));
        chk("R9 R11 almost-full", 32'(almost_full_n), 32'(!(cnt >= DEPTH - m_cur)));
        chk("R7 R8 R11 almost-empty", 32'(almost_empty_n), 32'(!(cnt <= n_cur)));
    endtask

    task automatic do_reset(int n, int m, logic def);
        @(negedge wclk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        empty_ofs = PW'(n); full_ofs = PW'(m); ofs_default = def;
        repeat (4) @(posedge rclk);
        @(negedge wclk);
        chk("R1 valid in reset", 32'(rd_valid_n), 32'd1);
        rst = 1'b0;
        model.delete();
        n_cur = def ? DEFO : n;
        m_cur = def ? DEFO : m;
        @(negedge wclk);
        chk("R1 valid", 32'(rd_valid_n), 32'd1);
        chk("R1 full", 32'(wr_space_n), 32'd0);
        chk("R1 half", 32'(half_full_n), 32'd1);
        chk("R1 afull", 32'(almost_full_n), 32'd1);
        chk("R1 aempty", 32'(almost_empty_n), 32'd0);
    endtask

    task automatic do_write(logic [8:0] d);
        @(negedge wclk);
        wr_en = 1'b1; din = d;
        @(negedge wclk);
        wr_en = 1'b0;
        if (model.size() < DEPTH + 1) model.push_back(d);
    endtask

    task automatic do_read();
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
        if (model.size() > 0) void'(model.pop_front());
    endtask

    task automatic sweep(int n, int m, logic def, int base);
        int lat;
        do_reset(n, m, def);
        // R4: read on empty output is ignored
        do_read();
        settle();
        check_flags();
        // R2: first word falls through
        @(negedge wclk);
        wr_en = 1'b1; din = val(base);
        @(posedge wclk);
        lat = 0;
        fork
            begin @(negedge wclk); wr_en = 1'b0; end
            begin
                while (rd_valid_n === 1'b1 && lat < 10) begin
                    @(posedge rclk); #0.5; lat++;
                end
            end
        join
        chk("R2 first-word latency window", 32'(lat >= 3 && lat <= 4), 32'd1);
        chk("R2 first word shown", 32'(dout), 32'(val(base)));
        model.push_back(val(base));
        settle();
        check_flags();
        for (int i = 1; i <= DEPTH + 2; i++) begin
            do_write(val(base + i));   // last two hit a full memory (R3)
            settle();
            check_flags();
        end
        while (model.size() > 0) begin
            do_read();
            settle();
            check_flags();
        end
        do_read();   // R4: ignored
        settle();
        check_flags();
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        $display("FAIL R5 watchdog actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        int widx, ridx;
        sweep(3, 5, 1'b0, 0);
        sweep(0, 0, 1'b0, 100);
        sweep(15, 15, 1'b0, 200);
        sweep(7, 9, 1'b1, 300);    // R11 default offsets override inputs

        // R5 concurrent traffic, reader throttled so the memory fills
        do_reset(3, 5, 1'b0);
        widx = 0; ridx = 0;
        fork
            begin
                while (widx < NSTR) begin
                    @(negedge wclk);
                    if (!wr_space_n) begin
                        wr_en = 1'b1; din = val(500 + widx); widx++;
                    end else wr_en = 1'b0;
                end
                @(negedge wclk);
                wr_en = 1'b0;
            end
            begin
                int tick = 0;
                while (ridx < NSTR) begin
                    @(negedge rclk);
                    tick++;
                    if (!rd_valid_n && (ridx > NSTR / 2 || tick % 3 == 0)) begin
                        chk("R5 stream order", 32'(dout), 32'(val(500 + ridx)));
                        ridx++;
                        rd_en = 1'b1;
                    end else rd_en = 1'b0;
                end
                @(negedge rclk);
                rd_en = 1'b0;
            end
        join
        settle();
        chk("R4 drained after stream", 32'(rd_valid_n), 32'd1);

        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule